// File: doc/BRIEF.md
# Compare-Match Timer Bank

This block holds a set of independent up-counting timer channels behind a small memory-mapped register port. Software sets each channel's clock source, prescaler, compare value and operating mode. Writing a channel's control register starts, stops or restarts it. A channel counts only on cycles where its selected tick input is asserted, and on a divide-by-two setting only on every second such tick. The chip's clock generator drives the two tick-enable inputs: one at the fast system rate and one at the 32 kHz real-time rate.

Each channel runs a three-state machine. `CH_STOP` is the state after reset and after any control write with the enable bit low; the counter is frozen there. `CH_RUN` is entered on any control write with the enable bit high. `CH_HELD` is entered from `CH_RUN` when a one-shot channel reaches its compare value; the counter is held there. The named transitions are:
- start: `CH_STOP`/`CH_HELD` to `CH_RUN`.
- halt: any state to `CH_STOP`.
- expire: `CH_RUN` to `CH_HELD`.
- reload: `CH_RUN` to `CH_RUN`, when a repeat-mode match returns the counter to zero.

A compare match sets a sticky per-channel pending bit. A single interrupt line reports every pending bit whose enable bit is set. Software clears pending bits by writing ones to the acknowledge register.

Top module: `tmr_bank`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low. All channels start in `CH_STOP`.
- R2: Channel n (1..NUM_CH) has four registers: control at byte address 0x10·n, clock configuration at 0x10·n+0x4, live counter (read-only) at 0x10·n+0x8, and compare at 0x10·n+0xC. The interrupt-enable register is at 0x00 and the acknowledge/pending register is at 0x08. Channel n owns bit n−1 of both shared registers. Unmapped addresses read zero.
- R3: In the control register, bit 0 enables the channel. Bit 1 zeroes the counter in the same write, so enable plus clear restarts from zero. Bits [5:4] select the mode: 0 is one-shot, 1 is repeat, 3 is free-running, and 2 behaves as free-running. Control reads back the enable bit and the mode, with bit 1 reading 0.
- R4: While a channel is disabled its counter holds its value. Re-enabling without the clear bit resumes from that value.
- R5: A running channel increments once per qualified tick. Clock configuration bit 4 selects the tick source: 0 is `tick_fast`, 1 is `tick_slow`. Bit 0 set means only every second tick of the selected source qualifies, and a control write with the clear bit restarts that phase. The other source has no effect.
- R6: On a qualified tick with the counter equal to compare in one-shot or repeat mode, the channel's pending bit is set. In repeat mode the counter returns to zero on that tick, so the period is compare+1 ticks.
- R7: In one-shot mode a match leaves the counter holding the compare value (`CH_HELD`) until a control write with enable set.
- R8: Free-running mode never sets the pending bit and wraps from 2^CNT_W−1 to 0.
- R9: Writing 1 to an acknowledge bit clears that pending bit. Writing 0 leaves it unchanged. A match in the same cycle as the acknowledge wins. Reading 0x08 returns the pending bits.
- R10: `irq_o` is high exactly when some channel has both its pending and enable bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Tick enable from the fast system clock |
| tick_slow | input | 1 | Tick enable from the 32 kHz real-time clock |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with six channels, an 8-bit counter, an 8-bit address and 32-bit data. With the 8-bit counter, a free-running wrap takes only 256 ticks, so R8's rollover can be reached directly. The six channels give room to run a repeat, a one-shot, a free-running channel and a slow divided channel side by side. Those channels then show that each ignores the others and ignores the tick source it did not select. The tick inputs are pulsed for exact counts, so every counter value and the cycle of every match are known in advance.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [1:0] {
        CH_STOP = 2'd0,
        CH_RUN  = 2'd1,
        CH_HELD = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        MD_ONCE = 2'd0,
        MD_LOOP = 2'd1,
        MD_RSVD = 2'd2,
        MD_FREE = 2'd3
    } ch_mode_e;

    // low nibble of the byte address inside a 16-byte bank
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_CFG  = 4'h4;
    localparam logic [3:0] OFS_CNT  = 4'h8;
    localparam logic [3:0] OFS_CMP  = 4'hC;

    // bank zero holds the shared registers
    localparam logic [3:0] OFS_IEN  = 4'h0;
    localparam logic [3:0] OFS_ACK  = 4'h8;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_fast,
    input  logic tick_slow,
    input  logic src_slow,
    input  logic div_two,
    input  logic resync,
    output logic tick_o
);

    logic sel_tick;
    logic half_q;

    assign sel_tick = src_slow ? tick_slow : tick_fast;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (resync) begin
            half_q <= 1'b0;
        end else if (sel_tick) begin
            half_q <= ~half_q;
        end
    end

    assign tick_o = sel_tick & (~div_two | half_q);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic             ctrl_clr,
    input  logic [1:0]       ctrl_mode,
    input  logic             cfg_wr,
    input  logic             cfg_src,
    input  logic             cfg_div,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_o,
    output logic [1:0]       mode_o,
    output logic             run_o,
    output logic             src_o,
    output logic             div_o,
    output logic             hit_o
);

    ch_state_e        state_q, state_d;
    ch_mode_e         mode_q;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_q;
    logic             src_q, div_q;
    logic             tick;
    logic             hit;
    logic             match_mode;

    tmr_prescale u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .src_slow  (src_q),
        .div_two   (div_q),
        .resync    (ctrl_wr & ctrl_clr),
        .tick_o    (tick)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_ONCE;
            cmp_q  <= '0;
            src_q  <= 1'b0;
            div_q  <= 1'b0;
        end else begin
            if (ctrl_wr) mode_q <= ch_mode_e'(ctrl_mode);
            if (cmp_wr)  cmp_q  <= cmp_wdata;
            if (cfg_wr) begin
                src_q <= cfg_src;
                div_q <= cfg_div;
            end
        end
    end

    // state and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign match_mode = (mode_q == MD_ONCE) || (mode_q == MD_LOOP);

    // next state, counter and match pulse
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        hit     = 1'b0;
        if (ctrl_wr) begin
            if (ctrl_clr) cnt_d = '0;
            state_d = ctrl_en ? CH_RUN : CH_STOP;   // start / halt
        end else begin
            unique case (state_q)
                CH_STOP: begin
                    state_d = CH_STOP;
                end
                CH_RUN: begin
                    if (tick) begin
                        if (match_mode && (cnt_q == cmp_q)) begin
                            hit = 1'b1;
                            if (mode_q == MD_LOOP) begin
                                cnt_d = '0;           // reload
                            end else begin
                                state_d = CH_HELD;    // expire
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                CH_HELD: begin
                    state_d = CH_HELD;
                end
                default: begin
                    state_d = CH_STOP;
                end
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign cmp_o  = cmp_q;
    assign mode_o = mode_q;
    assign run_o  = (state_q != CH_STOP);
    assign src_o  = src_q;
    assign div_o  = div_q;
    assign hit_o  = hit;

endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast,
    input  logic              tick_slow,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int BANK_W = ADDR_W - 4;

    logic [BANK_W-1:0]            bank;
    logic [3:0]                   ofs;
    logic [NUM_CH-1:0]            ctrl_wr_vec;
    logic [NUM_CH-1:0]            hit_vec;
    logic [NUM_CH-1:0]            run_vec;
    logic [NUM_CH-1:0]            src_vec;
    logic [NUM_CH-1:0]            div_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_vec;
    logic [NUM_CH-1:0][1:0]       mode_vec;
    logic [NUM_CH-1:0]            pend_q;
    logic [NUM_CH-1:0]            ien_q;
    logic                         glb_sel;
    logic [NUM_CH-1:0]            ack_mask;

    assign bank    = bus_addr[ADDR_W-1:4];
    assign ofs     = bus_addr[3:0];
    assign glb_sel = (bank == '0);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel            = (bank == BANK_W'(i + 1));
        assign ctrl_wr_vec[i] = bus_wr & sel & (ofs == OFS_CTRL);

        tmr_chan #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_fast (tick_fast),
            .tick_slow (tick_slow),
            .ctrl_wr   (ctrl_wr_vec[i]),
            .ctrl_en   (bus_wdata[0]),
            .ctrl_clr  (bus_wdata[1]),
            .ctrl_mode (bus_wdata[5:4]),
            .cfg_wr    (bus_wr & sel & (ofs == OFS_CFG)),
            .cfg_src   (bus_wdata[4]),
            .cfg_div   (bus_wdata[0]),
            .cmp_wr    (bus_wr & sel & (ofs == OFS_CMP)),
            .cmp_wdata (bus_wdata[CNT_W-1:0]),
            .cnt_o     (cnt_vec[i]),
            .cmp_o     (cmp_vec[i]),
            .mode_o    (mode_vec[i]),
            .run_o     (run_vec[i]),
            .src_o     (src_vec[i]),
            .div_o     (div_vec[i]),
            .hit_o     (hit_vec[i])
        );
    end

    assign ack_mask = (bus_wr && glb_sel && ofs == OFS_ACK) ? bus_wdata[NUM_CH-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            ien_q  <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_mask) | hit_vec;
            if (bus_wr && glb_sel && ofs == OFS_IEN) ien_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    assign irq_o = |(pend_q & ien_q);

    always_comb begin
        bus_rdata = '0;
        if (glb_sel) begin
            if (ofs == OFS_IEN) bus_rdata[NUM_CH-1:0] = ien_q;
            if (ofs == OFS_ACK) bus_rdata[NUM_CH-1:0] = pend_q;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (bank == BANK_W'(i + 1)) begin
                unique case (ofs)
                    OFS_CTRL: begin
                        bus_rdata[5:4] = mode_vec[i];
                        bus_rdata[0]   = run_vec[i];
                    end
                    OFS_CFG: begin
                        bus_rdata[4] = src_vec[i];
                        bus_rdata[0] = div_vec[i];
                    end
                    OFS_CNT: bus_rdata[CNT_W-1:0] = cnt_vec[i];
                    OFS_CMP: bus_rdata[CNT_W-1:0] = cmp_vec[i];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NUM_CH = 6,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_wr,
    input logic [ADDR_W-1:0]            bus_addr,
    input logic                         irq_o,
    input logic [NUM_CH-1:0]            pend_q,
    input logic [NUM_CH-1:0]            ien_q,
    input logic [NUM_CH-1:0]            hit_vec,
    input logic [NUM_CH-1:0]            run_vec,
    input logic [NUM_CH-1:0]            ctrl_wr_vec,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt_vec
);

    logic ack_wr;
    assign ack_wr = bus_wr && (bus_addr == ADDR_W'(8));

    // R1: interrupt stays low while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            a_r1_quiet_in_reset: assert (irq_o == 1'b0);
        end
    end

    // R9: pending bits only drop through an acknowledge write
    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_wr |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R10: no interrupt without an enabled channel
    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ien_q != '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R4: a stopped channel keeps its counter
        a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_vec[i] && !ctrl_wr_vec[i]) |=> (cnt_vec[i] == $past(cnt_vec[i])));

        // R6: a match is always recorded as pending
        a_r6_hit_pends: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[i] |=> pend_q[i]);
    end

endmodule

bind tmr_bank tmr_bank_chk #(
    .NUM_CH (NUM_CH),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .ien_q       (ien_q),
    .hit_vec     (hit_vec),
    .run_vec     (run_vec),
    .ctrl_wr_vec (ctrl_wr_vec),
    .cnt_vec     (cnt_vec)
);

// File: tb/test_tmr_bank.sv
`timescale 1ns/1ps
module test_tmr_bank;

    localparam int NUM_CH = 6;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_fast = 1'b0;
    logic              tick_slow = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    tmr_bank #(
        .NUM_CH (NUM_CH),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_tmr_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // monitor: compare mid-cycle, away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq_o} : bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // every task starts and ends 1 ns after a rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_fast = 1'b1;
        step();
        bus_wr = 1'b0; tick_fast = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic irq_chk(input logic e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        step();
    endtask

    task automatic tick_f(input int n);
        tick_fast = 1'b1;
        for (int k = 0; k < n; k++) step();
        tick_fast = 1'b0;
    endtask

    task automatic tick_s(input int n);
        tick_slow = 1'b1;
        for (int k = 0; k < n; k++) step();
        tick_slow = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();

        // R1 reset state
        rd(8'h10, 0, "R1 ctrl1");
        rd(8'h18, 0, "R1 cnt1");
        rd(8'h00, 0, "R1 ien");
        rd(8'h08, 0, "R1 pend");
        irq_chk(1'b0, "R1 irq");

        // channel 1: repeat, compare 10, fast, no divide
        wr(8'h1C, 10);
        wr(8'h14, 0);
        wr(8'h10, 32'h13);
        rd(8'h1C, 10, "R2 cmp1 readback");
        rd(8'h04, 0, "R2 unmapped");
        tick_f(4);
        rd(8'h18, 4, "R5 cnt1 after 4 ticks");

        // R4 disable freezes, resume without clear
        wr(8'h10, 32'h10);
        tick_f(3);
        rd(8'h18, 4, "R4 frozen");
        rd(8'h10, 32'h10, "R3 ctrl readback disabled");
        wr(8'h10, 32'h11);
        tick_f(2);
        rd(8'h18, 6, "R4 resumed");

        // R6 repeat match
        tick_f(4);
        rd(8'h08, 0, "R6 no pend before match");
        tick_f(1);
        rd(8'h08, 1, "R6 pend on match");
        rd(8'h18, 0, "R6 repeat reload");
        irq_chk(1'b0, "R10 masked");

        // R10 / R9
        wr(8'h00, 1);
        irq_chk(1'b1, "R10 enabled");
        wr(8'h08, 0);
        rd(8'h08, 1, "R9 zero ack no effect");
        wr(8'h08, 1);
        rd(8'h08, 0, "R9 ack clears");
        irq_chk(1'b0, "R10 cleared");
        wr(8'h10, 32'h10);

        // R7 one-shot on channel 2
        wr(8'h2C, 2);
        wr(8'h20, 32'h03);
        tick_f(3);
        rd(8'h28, 2, "R7 held at compare");
        rd(8'h08, 2, "R7 pend2");
        tick_f(4);
        rd(8'h28, 2, "R7 still held");
        wr(8'h20, 32'h03);
        tick_f(1);
        rd(8'h28, 1, "R7 restart");
        wr(8'h20, 32'h00);

        // R8 free-running on channel 3
        wr(8'h3C, 0);
        wr(8'h30, 32'h33);
        tick_f(5);
        rd(8'h38, 5, "R8 free count");
        rd(8'h08, 2, "R8 no pend3");
        tick_f(251);
        rd(8'h38, 0, "R8 wrap");
        rd(8'h08, 2, "R8 no pend3 after wrap");

        // R5 slow source, divide by two, on channel 4
        wr(8'h44, 32'h11);
        wr(8'h4C, 200);
        wr(8'h40, 32'h13);
        tick_f(4);
        rd(8'h48, 0, "R5 fast ignored by slow chan");
        tick_s(4);
        rd(8'h48, 2, "R5 div2 slow");
        rd(8'h38, 4, "R5 slow ignored by fast chan");
        rd(8'h44, 32'h11, "R5 cfg readback");
        rd(8'h40, 32'h11, "R3 ctrl readback clear reads 0");

        // R9 ack all
        wr(8'h08, 32'h3F);
        rd(8'h08, 0, "R9 ack all");

        // R9 match wins over same-cycle ack on channel 5
        wr(8'h5C, 0);
        wr(8'h50, 32'h03);
        wr_tick(8'h08, 32'h10);
        rd(8'h08, 32'h10, "R9 hit beats ack");
        irq_chk(1'b0, "R10 ch5 not enabled");
        wr(8'h00, 32'h10);
        irq_chk(1'b1, "R10 ch5 enabled");

        step();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule